// File: doc/BRIEF.md
# MESIF Cache Line Coherence Controller

This block holds the coherence state of every line in a small private cache that takes part in a five-state protocol: Invalid, Shared, Exclusive, Modified and Forward. Forward marks the one clean sharer that answers a read from another agent, so the other sharers stay silent. Each clock cycle the block can accept one event on one line. The event comes either from the local processor (load, store, eviction) or from the bus (snoop read, snoop read-for-ownership, invalidate). A fill flag tells it whether other caches already hold the line when a load miss fills.

For each event the block moves the line to its next state. One cycle later it reports that new state together with three things: a data-supply strobe, a writeback request, and the bus request the local cache must issue (read, read-for-ownership or upgrade). A combinational query port reads out the state of any line so that sequences of events can be observed. Data arrays, tag lookup and arbitration belong to the blocks around it.

The named states are ST_I, ST_S, ST_E, ST_M and ST_F. The named transitions are:
- fill-exclusive (I to E on a load with no sharers) and fill-forward (I to F on a load with sharers);
- silent-upgrade (E or M to M on a store), bus-upgrade (S or F to M on a store) and own-miss (I to M on a store);
- snoop-share (M, E or F to S on a snoop read) and snoop-kill (any state to I on a snoop read-for-ownership or an invalidate);
- evict (any state to I).

Top module: `mesif_line_ctrl`

## Requirements
- R1: After reset every line reads back state code 0 (Invalid) on the query port, and rsp_valid, rsp_supply and rsp_wb are low.
- R2: State codes are I=0, S=1, E=2, M=3, F=4. Event codes on evt_kind are LOAD=0, STORE=1, EVICT=2, SNOOP_READ=3, SNOOP_RFO=4, SNOOP_INV=5; codes 6 and 7 change nothing. Bus request codes are NONE=0, READ=1, RFO=2, UPGRADE=3.
- R3: A load to an Invalid line issues READ. The line fills to E when fill_shared is 0 and to F when fill_shared is 1.
- R4: A load to a line in S, E, M or F leaves its state unchanged and issues NONE.
- R5: A store to a line in E or M leaves it in M and issues NONE.
- R6: A store to a line in S or F issues UPGRADE and leaves the line in M.
- R7: A store to an Invalid line issues RFO and leaves the line in M.
- R8: A snoop read of an M line asserts both rsp_supply and rsp_wb, and the line goes to S.
- R9: A snoop read of an E or F line asserts rsp_supply without rsp_wb and the line goes to S. A snoop read of an S or I line supplies nothing and leaves the state unchanged.
- R10: A snoop read-for-ownership or an invalidate moves any line to I. rsp_supply is asserted for M, E and F, and rsp_wb only for M.
- R11: An eviction moves the line to I. rsp_wb is asserted only if the line was M, and no data is supplied.
- R12: The response appears in the cycle after the event, with rsp_valid high for exactly that cycle. An event changes only the line it names, and a cycle with no event gives rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_line | input | LINE_W | Line the event targets |
| evt_kind | input | 3 | Event code (R2) |
| fill_shared | input | 1 | Other sharers exist for a load-miss fill |
| qry_line | input | LINE_W | Line to read back |
| qry_state | output | 3 | Current state of qry_line |
| rsp_valid | output | 1 | Response for last cycle's event |
| rsp_state | output | 3 | New state of the line that was addressed |
| rsp_supply | output | 1 | This cache supplies the line's data |
| rsp_wb | output | 1 | Writeback of the dirty line requested |
| rsp_bus | output | 2 | Bus request the local cache must issue |

## Verification
The bench drives lines through whole sequences: from a clean fill to dirty, then shared, then upgraded and evicted. A design that lost the dirty bit would show up there as a missing writeback on the snoop read or the eviction. It also separates the fill flag at a load miss: mixing E and F up would make a later store upgrade without need, or skip the upgrade it needs. Snoop reads of a plain sharer and of an invalid line must stay silent, because a design that let every sharer answer would give more than one response. Finally, an event on one line must leave a neighbouring line untouched, which catches a wrong write-enable decode.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_M = 3'd3,
        ST_F = 3'd4
    } line_state_e;

    typedef enum logic [2:0] {
        EV_LOAD     = 3'd0,
        EV_STORE    = 3'd1,
        EV_EVICT    = 3'd2,
        EV_SNP_RD   = 3'd3,
        EV_SNP_RFO  = 3'd4,
        EV_SNP_INV  = 3'd5,
        EV_RSVD6    = 3'd6,
        EV_RSVD7    = 3'd7
    } line_evt_e;

    typedef enum logic [1:0] {
        BUS_NONE    = 2'd0,
        BUS_READ    = 2'd1,
        BUS_RFO     = 2'd2,
        BUS_UPGRADE = 2'd3
    } bus_req_e;

    typedef struct packed {
        line_state_e nxt;
        logic        supply;
        logic        wb;
        bus_req_e    bus;
    } line_action_t;

endpackage

// File: rtl/mesif_transition.sv
module mesif_transition
    import mesif_pkg::*;
(
    input  line_state_e  cur,
    input  line_evt_e    kind,
    input  logic         shared,
    output line_action_t act
);
    // Snoop response: shared by snoop read, snoop RFO and invalidate.
    function automatic line_action_t snoop_resp(line_state_e s, line_state_e tgt);
        line_action_t r;
        r.nxt    = s;
        r.supply = 1'b0;
        r.wb     = 1'b0;
        r.bus    = BUS_NONE;
        unique case (s)
            ST_M: begin
                r.nxt = tgt; r.supply = 1'b1; r.wb = 1'b1;
            end
            ST_E, ST_F: begin
                r.nxt = tgt; r.supply = 1'b1;
            end
            ST_S:    r.nxt = (tgt == ST_I) ? ST_I : ST_S;
            default: r.nxt = ST_I;
        endcase
        return r;
    endfunction

    always_comb begin
        act.nxt    = cur;
        act.supply = 1'b0;
        act.wb     = 1'b0;
        act.bus    = BUS_NONE;
        unique case (kind)
            EV_LOAD: begin
                if (cur == ST_I) begin
                    // fill-exclusive or fill-forward
                    act.bus = BUS_READ;
                    act.nxt = shared ? ST_F : ST_E;
                end
            end
            EV_STORE: begin
                unique case (cur)
                    ST_E, ST_M: act.nxt = ST_M;            // silent-upgrade
                    ST_S, ST_F: begin                      // bus-upgrade
                        act.nxt = ST_M;
                        act.bus = BUS_UPGRADE;
                    end
                    default: begin                         // own-miss
                        act.nxt = ST_M;
                        act.bus = BUS_RFO;
                    end
                endcase
            end
            EV_EVICT: begin
                act.nxt = ST_I;
                act.wb  = (cur == ST_M);
            end
            EV_SNP_RD:              act = snoop_resp(cur, ST_S);
            EV_SNP_RFO, EV_SNP_INV: act = snoop_resp(cur, ST_I);
            default: ;
        endcase
    end
endmodule

// File: rtl/mesif_state_table.sv
module mesif_state_table
    import mesif_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [LINE_W-1:0]   wr_line,
    input  line_state_e         wr_state,
    input  logic [LINE_W-1:0]   rd_a_line,
    output line_state_e         rd_a_state,
    input  logic [LINE_W-1:0]   rd_b_line,
    output line_state_e         rd_b_state
);
    localparam int NUM_LINES = 1 << LINE_W;

    line_state_e state_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                state_q[g] <= ST_I;
            else if (wr_en && (wr_line == LINE_W'(g)))
                state_q[g] <= wr_state;
        end
    end

    assign rd_a_state = state_q[rd_a_line];
    assign rd_b_state = state_q[rd_b_line];
endmodule

// File: rtl/mesif_resp_reg.sv
module mesif_resp_reg
    import mesif_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  line_action_t in_act,
    output logic         out_valid,
    output line_action_t out_act
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_act.nxt    <= ST_I;
            out_act.supply <= 1'b0;
            out_act.wb     <= 1'b0;
            out_act.bus    <= BUS_NONE;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_act <= in_act;
            end else begin
                out_act.supply <= 1'b0;
                out_act.wb     <= 1'b0;
                out_act.bus    <= BUS_NONE;
            end
        end
    end
endmodule

// File: rtl/mesif_line_ctrl.sv
module mesif_line_ctrl
    import mesif_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [LINE_W-1:0] evt_line,
    input  logic [2:0]        evt_kind,
    input  logic              fill_shared,
    input  logic [LINE_W-1:0] qry_line,
    output logic [2:0]        qry_state,
    output logic              rsp_valid,
    output logic [2:0]        rsp_state,
    output logic              rsp_supply,
    output logic              rsp_wb,
    output logic [1:0]        rsp_bus
);
    line_state_e  line_cur;
    line_state_e  qry_cur;
    line_action_t act;
    line_action_t rsp_act;
    line_evt_e    kind;

    assign kind = line_evt_e'(evt_kind);

    mesif_state_table #(.LINE_W(LINE_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (evt_valid),
        .wr_line    (evt_line),
        .wr_state   (act.nxt),
        .rd_a_line  (evt_line),
        .rd_a_state (line_cur),
        .rd_b_line  (qry_line),
        .rd_b_state (qry_cur)
    );

    mesif_transition u_fsm (
        .cur    (line_cur),
        .kind   (kind),
        .shared (fill_shared),
        .act    (act)
    );

    mesif_resp_reg u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (evt_valid),
        .in_act    (act),
        .out_valid (rsp_valid),
        .out_act   (rsp_act)
    );

    assign qry_state  = qry_cur;
    assign rsp_state  = rsp_act.nxt;
    assign rsp_supply = rsp_act.supply;
    assign rsp_wb     = rsp_act.wb;
    assign rsp_bus    = rsp_act.bus;
endmodule

// File: rtl/mesif_line_chk.sv
module mesif_line_chk
    import mesif_pkg::*;
#(
    parameter int LINE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [2:0]        evt_kind,
    input line_state_e       line_cur,
    input logic              rsp_valid,
    input logic [2:0]        rsp_state,
    input logic              rsp_supply,
    input logic              rsp_wb,
    input logic [1:0]        rsp_bus
);
    // R8
    wb_only_from_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wb |-> $past(evt_valid && line_cur == ST_M));

    // R5
    store_ends_modified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 3'd1) |=> (rsp_valid && rsp_state == 3'd3));

    // R10
    snoop_kill_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_kind == 3'd4 || evt_kind == 3'd5)) |=> (rsp_state == 3'd0));

    // R11
    evict_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 3'd2) |=> (rsp_state == 3'd0 && !rsp_supply));

    // R9
    sharer_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 3'd3 && line_cur == ST_S) |=> !rsp_supply);

    // R12
    idle_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> (!rsp_valid && !rsp_supply && !rsp_wb && rsp_bus == 2'd0));

    // R4
    bus_only_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_bus != 2'd0) |-> $past(evt_kind == 3'd0 || evt_kind == 3'd1));
endmodule

bind mesif_line_ctrl mesif_line_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .line_cur   (line_cur),
    .rsp_valid  (rsp_valid),
    .rsp_state  (rsp_state),
    .rsp_supply (rsp_supply),
    .rsp_wb     (rsp_wb),
    .rsp_bus    (rsp_bus)
);

// File: tb/tb_mesif_line_ctrl.sv
module tb_mesif_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W     = 3;

    // R2 encodings
    localparam int SI = 0, SS = 1, SE = 2, SM = 3, SF = 4;
    localparam int K_LD = 0, K_ST = 1, K_EV = 2, K_SRD = 3, K_SRFO = 4, K_SINV = 5;
    localparam int B_NONE = 0, B_RD = 1, B_RFO = 2, B_UPG = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              evt_valid = 1'b0;
    logic [LINE_W-1:0] evt_line = '0;
    logic [2:0]        evt_kind = '0;
    logic              fill_shared = 1'b0;
    logic [LINE_W-1:0] qry_line = '0;
    logic [2:0]        qry_state;
    logic              rsp_valid;
    logic [2:0]        rsp_state;
    logic              rsp_supply;
    logic              rsp_wb;
    logic [1:0]        rsp_bus;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesif_line_ctrl #(.LINE_W(LINE_W)) dut (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ev(input int line, input int kind, input bit shr, input string req,
                      input int e_st, input int e_bus, input bit e_sup, input bit e_wb);
        @(negedge clk);
        evt_valid = 1'b1; evt_line = LINE_W'(line); evt_kind = 3'(kind); fill_shared = shr;
        qry_line = LINE_W'(line);
        @(negedge clk);
        evt_valid = 1'b0;
        check({req, " rsp_valid"}, int'(rsp_valid), 1);
        check({req, " state"}, int'(rsp_state), e_st);
        check({req, " query"}, int'(qry_state), e_st);
        check({req, " bus"}, int'(rsp_bus), e_bus);
        check({req, " supply"}, int'(rsp_supply), int'(e_sup));
        check({req, " wb"}, int'(rsp_wb), int'(e_wb));
    endtask

    task automatic t_reset();
        for (int i = 0; i < (1 << LINE_W); i++) begin
            qry_line = LINE_W'(i);
            #1;
            check("R1 reset state", int'(qry_state), SI);
        end
        check("R1 rsp_valid", int'(rsp_valid), 0);
        check("R1 supply", int'(rsp_supply), 0);
        check("R1 wb", int'(rsp_wb), 0);
    endtask

    task automatic t_dirty_cycle();
        ev(0, K_LD,  0, "R3 fill excl",    SE, B_RD,   0, 0);
        ev(0, K_LD,  0, "R4 load hit E",   SE, B_NONE, 0, 0);
        check("R2 E code", SE, 2);
        ev(0, K_ST,  0, "R5 store E",      SM, B_NONE, 0, 0);
        ev(0, K_LD,  1, "R4 load hit M",   SM, B_NONE, 0, 0);
        ev(0, K_ST,  0, "R5 store M",      SM, B_NONE, 0, 0);
        ev(0, K_SRD, 0, "R8 snoop rd M",   SS, B_NONE, 1, 1);
        ev(0, K_ST,  0, "R6 store S",      SM, B_UPG,  0, 0);
        ev(0, K_EV,  0, "R11 evict M",     SI, B_NONE, 0, 1);
    endtask

    task automatic t_forward();
        ev(1, K_LD,  1, "R3 fill fwd",     SF, B_RD,   0, 0);
        ev(1, K_SRD, 0, "R9 snoop rd F",   SS, B_NONE, 1, 0);
        ev(1, K_SRD, 0, "R9 snoop rd S",   SS, B_NONE, 0, 0);
        ev(1, K_LD,  0, "R4 load hit S",   SS, B_NONE, 0, 0);
        ev(2, K_LD,  1, "R3 fill fwd 2",   SF, B_RD,   0, 0);
        ev(2, K_ST,  0, "R6 store F",      SM, B_UPG,  0, 0);
        ev(4, K_LD,  0, "R3 fill excl 4",  SE, B_RD,   0, 0);
        ev(4, K_SRD, 0, "R9 snoop rd E",   SS, B_NONE, 1, 0);
    endtask

    task automatic t_kill();
        ev(3, K_ST,   0, "R7 store I",     SM, B_RFO,  0, 0);
        ev(3, K_SRFO, 0, "R10 rfo M",      SI, B_NONE, 1, 1);
        ev(5, K_LD,   0, "R3 fill 5",      SE, B_RD,   0, 0);
        ev(5, K_SINV, 0, "R10 inv E",      SI, B_NONE, 1, 0);
        ev(5, K_SRD,  0, "R9 snoop rd I",  SI, B_NONE, 0, 0);
        ev(6, K_LD,   1, "R3 fill 6",      SF, B_RD,   0, 0);
        ev(6, K_SRFO, 0, "R10 rfo F",      SI, B_NONE, 1, 0);
        ev(7, K_LD,   1, "R3 fill 7",      SF, B_RD,   0, 0);
        ev(7, K_SRD,  0, "R9 rd F->S",     SS, B_NONE, 1, 0);
        ev(7, K_SINV, 0, "R10 inv S",      SI, B_NONE, 0, 0);
        ev(6, K_LD,   1, "R3 refill 6",    SF, B_RD,   0, 0);
        ev(6, K_EV,   0, "R11 evict F",    SI, B_NONE, 0, 0);
    endtask

    task automatic t_isolation();
        ev(0, K_LD, 0, "R12 setup",        SE, B_RD,   0, 0);
        ev(1, K_SINV, 0, "R12 other line", SI, B_NONE, 0, 0);
        qry_line = LINE_W'(0);
        #1;
        check("R12 neighbour untouched", int'(qry_state), SE);
        @(negedge clk);
        check("R12 idle rsp_valid", int'(rsp_valid), 0);
        ev(0, 6, 0, "R2 reserved code",    SE, B_NONE, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_dirty_cycle();
        t_forward();
        t_kill();
        t_isolation();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule